// File: doc/BRIEF.md
# DLL Lock and Latency-Mode Sequencer

This block decides when a memory's internal delay-locked loop may be treated as locked, and which read-latency mode the memory's datapath should use. The loop itself is not modelled. The block only tracks the conditions under which it is trusted. It counts rising edges of a steady memory clock before it declares lock. It watches the memory clock from a free-running reference clock, so that a stopped or badly slowed clock can be seen. When that happens, it throws lock away and counts again from zero.

An enable pin picks the operating mode. With the pin high, the loop is in use and the datapath runs at normal latency. With the pin low, the loop is treated as off and the block selects a fallback mode with one cycle of read latency. A change in mode is held back while a read burst is in flight. The block also issues a single-cycle pulse at a fixed interval of memory-clock cycles, which asks the output drivers to recalibrate their impedance.

The gap threshold is a time, given as `GAP_NS`. It is turned into a whole number of reference-clock periods from `REF_MHZ`. With the defaults (30 ns, 200 MHz) that gives 6 reference cycles.

Top module: `dll_lock_seq`

## Requirements
- R1: With `dll_en` high and the memory clock steady from reset, `dll_locked` is low through the 1023rd rising edge of `mem_clk` after reset release and goes high at the 1024th (`LOCK_CYC`).
- R2: If no `mem_clk` edge arrives for `GAP_REF_CYC` reference-clock periods, `dll_locked` is low after the third `mem_clk` rising edge once the clock resumes.
- R3: After such a gap, lock returns with no outside action at rising edge 1027 after the clock resumes (3 synchronizer edges plus `LOCK_CYC`), and not before.
- R4: Driving `dll_en` low makes `lat_fallback` read 1 (1 = one-cycle fallback latency, 0 = normal latency) and clears `dll_locked`, both by the third rising edge of `mem_clk` after the change, when no read burst is in flight.
- R5: Driving `dll_en` high again returns `lat_fallback` to 0 by the third edge. Lock is then relearned and rises at the 1026th edge after the change.
- R6: While `rd_busy` is high, `lat_fallback` keeps its value whatever `dll_en` does. The pending change takes effect on the first edge at which `rd_busy` is low.
- R7: `zq_cal` is high for exactly one `mem_clk` cycle after rising edges 1024, 2048, … (`ZQ_PERIOD`) counted from reset release, and low otherwise.
- R8: During reset, `dll_locked`, `lat_fallback` and `zq_cal` are all 0.
- R9: A memory-clock period that stays below the gap threshold (for example 24 ns against 30 ns) does not disturb an acquired lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_clk | input | 1 | Memory clock whose stability is judged |
| ref_clk | input | 1 | Free-running reference clock used to time clock gaps |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dll_en | input | 1 | Loop enable pin: 1 = loop in use, 0 = loop off (fallback mode) |
| rd_busy | input | 1 | High while a read burst is in progress |
| dll_locked | output | 1 | Loop is considered locked |
| lat_fallback | output | 1 | 1 = one-cycle fallback latency, 0 = normal latency |
| zq_cal | output | 1 | One-cycle impedance recalibration request |

## Verification
On every clock, the assertions check the following:
- lock never survives a restart event or a disabled loop;
- lock never rises before the memory clock has run long enough without interruption;
- the latency mode holds still during a read burst;
- calibration pulses are spaced exactly one period apart;
- a seen memory-clock edge never counts as a stop.

Some behaviours can only be shown by the bench's scenarios. These are the exact edge on which lock first appears, the way a real clock stop in the bench's clock generator is carried across domains and ends in relock, and the fact that a merely stretched period leaves lock alone.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

   typedef enum logic {
      LAT_NORMAL   = 1'b0,
      LAT_FALLBACK = 1'b1
   } lat_mode_e;

   // Whole reference periods covering a gap of ns at mhz, rounded up.
   function automatic int gap_ref_cycles(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/dll_sync.sv
module dll_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dll_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dll_gap_detect.sv
module dll_gap_detect #(
   parameter int GAP_REF_CYC = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic edge_tgl,   // flips on every memory-clock edge
   output logic stop_tgl    // flips once per detected clock stop
);

   generate
      if (GAP_REF_CYC < 3) begin : g_bad_gap
         $error("dll_gap_detect: GAP_REF_CYC must be at least 3");
      end
   endgenerate

   localparam int IW = $clog2(GAP_REF_CYC + 1);
   localparam logic [IW-1:0] FIRE_AT = IW'(GAP_REF_CYC - 2);

   logic          tgl_s, tgl_prev, seen;
   logic [IW-1:0] idle;
   logic          armed;

   dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_edge_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(edge_tgl), .q(tgl_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) tgl_prev <= 1'b0;
      else        tgl_prev <= tgl_s;
   end

   assign seen = tgl_s ^ tgl_prev;

   // Armed only after an edge has been seen, so reset release never fires.
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         idle     <= '0;
         armed    <= 1'b0;
         stop_tgl <= 1'b0;
      end else if (seen) begin
         idle  <= '0;
         armed <= 1'b1;
      end else if (armed) begin
         if (idle == FIRE_AT) begin
            stop_tgl <= ~stop_tgl;
            armed    <= 1'b0;
            idle     <= '0;
         end else begin
            idle <= idle + 1'b1;
         end
      end
   end

   AST_EDGE_NOT_STOP: assert property (@(posedge ref_clk) disable iff (!rst_n)
      seen |=> $stable(stop_tgl)); // R9

endmodule

// File: rtl/dll_lock_ctr.sv
module dll_lock_ctr
   import dll_seq_pkg::*;
#(
   parameter int LOCK_CYC = 1024
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en_s,
   input  logic      restart,
   input  logic      rd_busy,
   output logic      locked,
   output lat_mode_e lat_mode
);

   generate
      if (LOCK_CYC < 2) begin : g_bad_lock
         $error("dll_lock_ctr: LOCK_CYC must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(LOCK_CYC);
   localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         locked <= 1'b0;
      end else if (!en_s || restart) begin
         cnt    <= '0;
         locked <= 1'b0;
      end else if (!locked) begin
         if (cnt == LAST) locked <= 1'b1;
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat_mode <= LAT_NORMAL;
      else if (!rd_busy) lat_mode <= en_s ? LAT_NORMAL : LAT_FALLBACK;
   end

   // Independent run-length counter for the lock check.
   logic [CW:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run <= '0;
      else if (!en_s || restart)   run <= '0;
      else if (run != (CW+1)'(LOCK_CYC)) run <= run + 1'b1;
   end

   AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> run == (CW+1)'(LOCK_CYC)); // R1
   AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !locked); // R2
   AST_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> !locked); // R4
   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |=> $stable(lat_mode)); // R6

endmodule

// File: rtl/dll_zq_timer.sv
module dll_zq_timer #(
   parameter int ZQ_PERIOD = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse
);

   generate
      if (ZQ_PERIOD < 2) begin : g_bad_period
         $error("dll_zq_timer: ZQ_PERIOD must be at least 2");
      end
   endgenerate

   localparam int PW = $clog2(ZQ_PERIOD);
   localparam logic [PW-1:0] LAST = PW'(ZQ_PERIOD - 1);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else begin
         cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
         pulse <= (cnt == LAST);
      end
   end

   logic [PW:0] since;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     since <= '0;
      else if (pulse) since <= (PW+1)'(1);
      else            since <= since + 1'b1;
   end

   AST_ZQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> since == (PW+1)'(ZQ_PERIOD)); // R7
   AST_ZQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R7

endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
   import dll_seq_pkg::*;
#(
   parameter int LOCK_CYC    = 1024,
   parameter int ZQ_PERIOD   = 1024,
   parameter bit ZQ_EN       = 1'b1,
   parameter int REF_MHZ     = 200,
   parameter int GAP_NS      = 30,
   parameter int SYNC_STAGES = 2
) (
   input  logic mem_clk,
   input  logic ref_clk,
   input  logic rst_n,
   input  logic dll_en,
   input  logic rd_busy,
   output logic dll_locked,
   output logic lat_fallback,
   output logic zq_cal
);

   localparam int GAP_REF_CYC = gap_ref_cycles(GAP_NS, REF_MHZ);

   logic      edge_tgl, stop_tgl, stop_s, stop_prev, restart, en_s;
   lat_mode_e mode;

   always_ff @(posedge mem_clk or negedge rst_n) begin
      if (!rst_n) edge_tgl <= 1'b0;
      else        edge_tgl <= ~edge_tgl;
   end

   dll_gap_detect #(.GAP_REF_CYC(GAP_REF_CYC), .SYNC_STAGES(SYNC_STAGES)) u_gap (
      .ref_clk(ref_clk), .rst_n(rst_n), .edge_tgl(edge_tgl), .stop_tgl(stop_tgl)
   );

   dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stop_sync (
      .clk(mem_clk), .rst_n(rst_n), .d(stop_tgl), .q(stop_s)
   );

   always_ff @(posedge mem_clk or negedge rst_n) begin
      if (!rst_n) stop_prev <= 1'b0;
      else        stop_prev <= stop_s;
   end

   assign restart = stop_s ^ stop_prev;

   dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
      .clk(mem_clk), .rst_n(rst_n), .d(dll_en), .q(en_s)
   );

   dll_lock_ctr #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk(mem_clk), .rst_n(rst_n), .en_s(en_s), .restart(restart),
      .rd_busy(rd_busy), .locked(dll_locked), .lat_mode(mode)
   );

   assign lat_fallback = (mode == LAT_FALLBACK);

   generate
      if (ZQ_EN) begin : g_zq
         dll_zq_timer #(.ZQ_PERIOD(ZQ_PERIOD)) u_zq (
            .clk(mem_clk), .rst_n(rst_n), .pulse(zq_cal)
         );
      end else begin : g_no_zq
         assign zq_cal = 1'b0;
      end
   endgenerate

   AST_RESET_QUIET: assert property (@(posedge mem_clk)
      !rst_n |-> (!dll_locked && !lat_fallback && !zq_cal)); // R8

endmodule

// File: tb/test_dll_lock_seq.sv
`timescale 1ns/100ps
module test_dll_lock_seq;

   logic mem_clk = 1'b0;
   logic ref_clk = 1'b0;
   logic rst_n = 1'b0;
   logic dll_en = 1'b1;
   logic rd_busy = 1'b0;
   logic dll_locked, lat_fallback, zq_cal;

   int   half_ns = 10;      // 50 MHz memory clock
   bit   clk_stop = 1'b0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;

   dll_lock_seq i_dll_lock_seq (
      .mem_clk(mem_clk), .ref_clk(ref_clk), .rst_n(rst_n), .dll_en(dll_en),
      .rd_busy(rd_busy), .dll_locked(dll_locked), .lat_fallback(lat_fallback),
      .zq_cal(zq_cal)
   );

   initial begin
      forever begin
         #(half_ns) mem_clk = 1'b1;
         #(half_ns) mem_clk = 1'b0;
         while (clk_stop) #1;
      end
   end

   initial begin
      #1;
      forever #2.5 ref_clk = ~ref_clk;   // 200 MHz reference
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge mem_clk);
      #3;
   endtask

   // pin, busy, expected lat_fallback, expected dll_locked (3 edges later)
   typedef struct packed { logic pin; logic busy; logic lat; logic lock; } vec_t;
   localparam vec_t VECS [7] = '{
      '{1'b1, 1'b0, 1'b0, 1'b1},
      '{1'b0, 1'b1, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b1, 1'b0},
      '{1'b1, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b1, 1'b0},
      '{1'b1, 1'b0, 1'b0, 1'b0}
   };

   initial begin
      // R8: reset state
      #35;
      chk("R8 locked", dll_locked, 1'b0);
      chk("R8 lat", lat_fallback, 1'b0);
      chk("R8 zq", zq_cal, 1'b0);
      @(posedge mem_clk); #3 rst_n = 1'b1;

      // R1 and R7 from reset release
      tick(1023);
      chk("R1 locked@1023", dll_locked, 1'b0);
      chk("R7 zq@1023", zq_cal, 1'b0);
      tick(1);
      chk("R1 locked@1024", dll_locked, 1'b1);
      chk("R7 zq@1024", zq_cal, 1'b1);
      tick(1);
      chk("R7 zq@1025", zq_cal, 1'b0);
      tick(1022);
      chk("R7 zq@2047", zq_cal, 1'b0);
      tick(1);
      chk("R7 zq@2048", zq_cal, 1'b1);

      // R9: stretched periods below the gap threshold
      @(posedge mem_clk); #2 half_ns = 12;
      @(posedge mem_clk); #2 half_ns = 10;
      tick(10);
      chk("R9 locked after stretch", dll_locked, 1'b1);

      // R2/R3: clock stop of 200 ns
      @(posedge mem_clk); #2 clk_stop = 1'b1;
      #200 clk_stop = 1'b0;
      tick(3);
      chk("R2 locked after stop", dll_locked, 1'b0);
      tick(1023);
      chk("R3 locked@1026", dll_locked, 1'b0);
      tick(1);
      chk("R3 locked@1027", dll_locked, 1'b1);

      // R4/R5/R6: mode table
      foreach (VECS[i]) begin
         dll_en = VECS[i].pin;
         rd_busy = VECS[i].busy;
         tick(3);
         chk($sformatf("R4/R5/R6 vec%0d lat", i), lat_fallback, VECS[i].lat);
         chk($sformatf("R4/R5 vec%0d lock", i), dll_locked, VECS[i].lock);
      end

      // R5: relock after last table entry re-enabled the loop
      tick(1022);
      chk("R5 locked@1025", dll_locked, 1'b0);
      tick(1);
      chk("R5 locked@1026", dll_locked, 1'b1);

      // R6: busy held across disable, then released
      rd_busy = 1'b1; dll_en = 1'b0;
      tick(5);
      chk("R6 lat held", lat_fallback, 1'b0);
      rd_busy = 1'b0;
      tick(1);
      chk("R6 lat after release", lat_fallback, 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #3000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule